// File: doc/BRIEF.md
# Page Table Group Search Walker

This block walks one hashed page table entry group at a time over a narrow 32-bit memory port. A hash unit outside the block supplies the byte address of the primary group and of the secondary group, together with the compare word that a matching entry must hold in its first word for each of the two passes. The walker fetches the tag word of every entry in turn and stops at the first exact match. It then fetches the mapping word and derives the real address and the read and write rights. Before it reports the outcome, it marks the entry as referenced and, for a permitted store, as changed. Each flag is set with a single byte write.

A lookup enters through a valid/ready request channel. `req_ready` is high only while the walker is idle, and a source that sees it low keeps `req_valid` and every request field steady until a rising edge where both are high. From then on the walker owns the memory port until it raises `done` for one cycle. The memory port carries one access at a time. A request stays asserted with stable address, lane enables and data until the memory answers with `mem_ack`. Lane enable bit k selects byte offset k of the word, and the bytes are big-endian, so offset 0 is bits 31:24 and offset 3 is bits 7:0.

Top module: `ptg_walker`

## Requirements
- R1: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the walker is idle again, and the request fields are captured at acceptance.
- R2: Entry i of a group has its tag word at group base + 8*i and its mapping word at base + 8*i + 4. Tag words are read in ascending index order, and the first tag equal to the compare word ends the scan, followed by one read of that entry's mapping word.
- R3: On a match, `done_raddr` is the mapping word with bits 11:0 replaced by `req_offset`.
- R4: The effective protection code is mapping-word bits 1:0 with bit 2 added when (`req_user` and `req_key_user`) or (not `req_user` and `req_key_sup`).
- R5: Codes 0, 1, 2 and 6 grant read and write. Codes 3, 5 and 7 grant read only. Code 4 grants neither. These appear on `done_read_ok` and `done_write_ok`.
- R6: If read is granted and mapping-word bit 8 (referenced) is clear, the walker writes the mapping-word address with `mem_be` = 4'b0100, carrying the word with bit 8 set.
- R7: If the access is a write, write is granted and bit 7 (changed) is clear, the walker writes the mapping-word address with `mem_be` = 4'b1000 and bit 7 set. This write comes after any referenced write.
- R8: `done_status` is 2'b01 (protection fault) when read is not granted or a write is not granted, and 2'b00 (hit) otherwise. The flag writes of R6 and R7 happen before either is reported.
- R9: A primary group without a match is followed by a scan of the secondary group using the secondary compare word. If that scan also misses, `done_status` is 2'b10, with no writes and zero rights.
- R10: Reads use all four lanes. A request holds its address, direction and lanes until `mem_ack`, and only one access is outstanding.
- R11: `done` is a single-cycle pulse, and the walker is idle with `req_ready` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_pri_base | input | 32 | Byte address of the primary group |
| req_sec_base | input | 32 | Byte address of the secondary group |
| req_pri_cmp | input | 32 | Tag compare word for the primary pass |
| req_sec_cmp | input | 32 | Tag compare word for the secondary pass |
| req_offset | input | 12 | Page offset of the effective address |
| req_user | input | 1 | Access made in user mode |
| req_key_user | input | 1 | Segment key applied in user mode |
| req_key_sup | input | 1 | Segment key applied in supervisor mode |
| req_write | input | 1 | Access is a store |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Lane enables, bit k = byte offset k |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result pulse |
| done_status | output | 2 | 00 hit, 01 protection fault, 10 not found |
| done_raddr | output | 32 | Real address of the hit |
| done_read_ok | output | 1 | Read granted |
| done_write_ok | output | 1 | Write granted |

## Verification
Two entries in the same group carry the matching tag. A walker that kept scanning past the first match would return the later entry's real address and make too many reads. Each protection code is reached through a different combination of key and mode. A design that applied the key in the wrong mode would hand out write rights for code 4 or withhold them for code 6. The flag updates are checked for lane, order and count: setting both flags in one word write, writing when the flag is already set, or skipping the referenced update on a fault would each show up as the wrong memory contents or the wrong number of writes. A miss in the primary group with the secondary compare word planted there checks that the second pass really switches both the base and the compare word. A slow memory checks that requests are held until acknowledged.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_TAG,
    S_RD_MAP,
    S_EVAL,
    S_SET_REF,
    S_SET_CHG,
    S_DONE
  } walk_state_t;

  localparam logic [1:0] RES_HIT  = 2'b00;
  localparam logic [1:0] RES_PROT = 2'b01;
  localparam logic [1:0] RES_MISS = 2'b10;
endpackage

// File: rtl/ptg_addr_gen.sv
module ptg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              map_word,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFS_W = IDX_W + 3;
  logic [OFS_W-1:0] ofs;
  assign ofs  = {idx, map_word, 2'b00};
  assign addr = base + ADDR_W'(ofs);
endmodule

// File: rtl/ptg_perm_decode.sv
module ptg_perm_decode (
  input  logic [1:0] pp,
  input  logic       user,
  input  logic       key_user,
  input  logic       key_sup,
  output logic [2:0] code,
  output logic       rd_ok,
  output logic       wr_ok
);
  logic key_on;
  assign key_on = (user && key_user) || (!user && key_sup);
  assign code   = {key_on, pp};

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    case (code)
      3'd0, 3'd1, 3'd2, 3'd6: begin
        rd_ok = 1'b1;
        wr_ok = 1'b1;
      end
      3'd3, 3'd5, 3'd7: rd_ok = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptg_walker.sv
module ptg_walker
  import ptg_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int OFF_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_pri_base,
  input  logic [WORD_W-1:0] req_sec_base,
  input  logic [WORD_W-1:0] req_pri_cmp,
  input  logic [WORD_W-1:0] req_sec_cmp,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              req_user,
  input  logic              req_key_user,
  input  logic              req_key_sup,
  input  logic              req_write,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [WORD_W-1:0] done_raddr,
  output logic              done_read_ok,
  output logic              done_write_ok
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);
  localparam logic [BE_W-1:0] BE_ALL = '1;
  localparam logic [BE_W-1:0] BE_REF = BE_W'(1) << 2;
  localparam logic [BE_W-1:0] BE_CHG = BE_W'(1) << 3;

  walk_state_t       state_q;
  logic [WORD_W-1:0] pri_base_q, sec_base_q, pri_cmp_q, sec_cmp_q;
  logic [OFF_W-1:0]  off_q;
  logic              user_q, kuser_q, ksup_q, wr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              in_sec_q;
  logic [WORD_W-1:0] map_q;
  logic [1:0]        status_q;
  logic [WORD_W-1:0] raddr_q;
  logic              rd_q, wr_ok_q;

  logic [WORD_W-1:0] cur_base, cur_cmp, acc_addr;
  logic [2:0]        prot_code;
  logic              perm_rd, perm_wr, map_sel;

  assign cur_base = in_sec_q ? sec_base_q : pri_base_q;
  assign cur_cmp  = in_sec_q ? sec_cmp_q  : pri_cmp_q;
  assign map_sel  = (state_q != S_RD_TAG);

  ptg_addr_gen #(.ADDR_W(WORD_W), .IDX_W(IDX_W)) u_addr (
    .base     (cur_base),
    .idx      (idx_q),
    .map_word (map_sel),
    .addr     (acc_addr)
  );

  ptg_perm_decode u_perm (
    .pp       (map_q[1:0]),
    .user     (user_q),
    .key_user (kuser_q),
    .key_sup  (ksup_q),
    .code     (prot_code),
    .rd_ok    (perm_rd),
    .wr_ok    (perm_wr)
  );

  // memory port drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_be    = BE_ALL;
    mem_wdata = map_q;
    case (state_q)
      S_RD_TAG, S_RD_MAP: mem_req = 1'b1;
      S_SET_REF: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = BE_REF;
        mem_wdata = map_q | (WORD_W'(1) << REF_BIT);
      end
      S_SET_CHG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = BE_CHG;
        mem_wdata = map_q | (WORD_W'(1) << CHG_BIT);
      end
      default: ;
    endcase
  end
  assign mem_addr = acc_addr;

  assign req_ready     = (state_q == S_IDLE);
  assign done          = (state_q == S_DONE);
  assign done_status   = status_q;
  assign done_raddr    = raddr_q;
  assign done_read_ok  = rd_q;
  assign done_write_ok = wr_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pri_base_q <= '0;
      sec_base_q <= '0;
      pri_cmp_q  <= '0;
      sec_cmp_q  <= '0;
      off_q      <= '0;
      user_q     <= 1'b0;
      kuser_q    <= 1'b0;
      ksup_q     <= 1'b0;
      wr_q       <= 1'b0;
      idx_q      <= '0;
      in_sec_q   <= 1'b0;
      map_q      <= '0;
      status_q   <= RES_MISS;
      raddr_q    <= '0;
      rd_q       <= 1'b0;
      wr_ok_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            pri_base_q <= req_pri_base;
            sec_base_q <= req_sec_base;
            pri_cmp_q  <= req_pri_cmp;
            sec_cmp_q  <= req_sec_cmp;
            off_q      <= req_offset;
            user_q     <= req_user;
            kuser_q    <= req_key_user;
            ksup_q     <= req_key_sup;
            wr_q       <= req_write;
            idx_q      <= '0;
            in_sec_q   <= 1'b0;
            state_q    <= S_RD_TAG;
          end
        end
        S_RD_TAG: begin
          if (mem_ack) begin
            if (mem_rdata == cur_cmp) begin
              state_q <= S_RD_MAP;
            end else if (idx_q != LAST_IDX) begin
              idx_q <= idx_q + 1'b1;
            end else if (!in_sec_q) begin
              idx_q    <= '0;
              in_sec_q <= 1'b1;
            end else begin
              status_q <= RES_MISS;
              raddr_q  <= '0;
              rd_q     <= 1'b0;
              wr_ok_q  <= 1'b0;
              state_q  <= S_DONE;
            end
          end
        end
        S_RD_MAP: begin
          if (mem_ack) begin
            map_q   <= mem_rdata;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          rd_q     <= perm_rd;
          wr_ok_q  <= perm_wr;
          raddr_q  <= {map_q[WORD_W-1:OFF_W], off_q};
          status_q <= (!perm_rd || (wr_q && !perm_wr)) ? RES_PROT : RES_HIT;
          if (perm_rd && !map_q[REF_BIT])
            state_q <= S_SET_REF;
          else if (wr_q && perm_wr && !map_q[CHG_BIT])
            state_q <= S_SET_CHG;
          else
            state_q <= S_DONE;
        end
        S_SET_REF: begin
          if (mem_ack) begin
            map_q[REF_BIT] <= 1'b1;
            if (wr_q && wr_ok_q && !map_q[CHG_BIT])
              state_q <= S_SET_CHG;
            else
              state_q <= S_DONE;
          end
        end
        S_SET_CHG: begin
          if (mem_ack) begin
            map_q[CHG_BIT] <= 1'b1;
            state_q        <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)); // R10
  AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_be == BE_ALL); // R10
  AST_FLAG_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> $countones(mem_be) == 1); // R6
  AST_CHG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be[3] |-> wr_q && done_write_ok && done_read_ok); // R7
  AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_write_ok |-> done_read_ok); // R5
  AST_HIT_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_status == RES_HIT |-> done_read_ok && (!wr_q || done_write_ok)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R11
endmodule

// File: tb/ptg_walker_tb.sv
module ptg_walker_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pri_base = '0, req_sec_base = '0, req_pri_cmp = '0, req_sec_cmp = '0;
  logic [11:0] req_offset = '0;
  logic        req_user = 1'b0, req_key_user = 1'b0, req_key_sup = 1'b0, req_write = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        done, done_read_ok, done_write_ok;
  logic [1:0]  done_status;
  logic [31:0] done_raddr;

  always #(CLK_P/2) clk = ~clk;

  ptg_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pri_base(req_pri_base), .req_sec_base(req_sec_base),
    .req_pri_cmp(req_pri_cmp), .req_sec_cmp(req_sec_cmp), .req_offset(req_offset),
    .req_user(req_user), .req_key_user(req_key_user), .req_key_sup(req_key_sup),
    .req_write(req_write), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .done_status(done_status), .done_raddr(done_raddr),
    .done_read_ok(done_read_ok), .done_write_ok(done_write_ok)
  );

  // behavioural memory: 256 words, all writes go through this process
  logic [31:0] mem [0:255];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_idx = '0;
  logic [31:0] poke_val = '0;
  int          lat = 0;
  int          wcnt, n_rd, n_wr, hold_err;
  logic [3:0]  wlog [0:3];
  logic [31:0] prev_addr;

  always @(posedge clk) begin
    if (poke_en) mem[poke_idx] <= poke_val;
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= 0; n_rd <= 0; n_wr <= 0; hold_err <= 0;
      mem_rdata <= '0; prev_addr <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && wcnt != 0 && mem_addr != prev_addr) hold_err <= hold_err + 1;
      prev_addr <= mem_addr;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          wcnt    <= 0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            for (int k = 0; k < 4; k++)
              if (mem_be[k]) mem[mem_addr[9:2]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
            wlog[n_wr[1:0]] <= mem_be;
            n_wr <= n_wr + 1;
          end else begin
            mem_rdata <= mem[mem_addr[9:2]];
            n_rd <= n_rd + 1;
          end
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  int checks = 0, fails = 0, cycles = 0;
  logic wdog_hit = 1'b0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG) wdog_hit <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] baddr, input logic [31:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = baddr[9:2]; poke_val = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic clear_groups();
    for (int g = 1; g < 4; g++)
      for (int i = 0; i < 8; i++) begin
        poke(32'(g * 256 + 8 * i), 32'h0000_1000 + 32'(i));
        poke(32'(g * 256 + 8 * i + 4), 32'h0);
      end
  endtask

  localparam logic [31:0] PB = 32'h100, SB = 32'h200;
  localparam logic [31:0] CP = 32'h8123_4567, CS = 32'h8123_45A7;

  logic [1:0]  r_st;
  logic [31:0] r_ra;
  logic        r_rd, r_wr;
  int          d_rd, d_wr, busy_ready;

  task automatic walk(input logic [11:0] off, input bit user, input bit ku,
                      input bit ks, input bit wr);
    int rd0, wr0, n;
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr; busy_ready = 0;
    req_pri_base = PB; req_sec_base = SB; req_pri_cmp = CP; req_sec_cmp = CS;
    req_offset = off; req_user = user; req_key_user = ku; req_key_sup = ks;
    req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_pri_cmp = 32'h0; req_sec_cmp = 32'h0; req_offset = 12'h0;
    n = 0;
    while (!done && !wdog_hit) begin
      if (req_ready) busy_ready++;
      @(negedge clk);
      n++;
    end
    r_st = done_status; r_ra = done_raddr; r_rd = done_read_ok; r_wr = done_write_ok;
    @(negedge clk);
    chk(!done && req_ready, "R11", "done pulse then idle", {30'd0, done, req_ready}, 32'h1);
    d_rd = n_rd - rd0; d_wr = n_wr - wr0;
  endtask

  // S1: read hit at idx 3 with a later duplicate; referenced set
  task automatic t_first_match();
    clear_groups();
    poke(PB + 24, CP); poke(PB + 28, 32'h0012_3002);
    poke(PB + 40, CP); poke(PB + 44, 32'h00AB_C002);
    walk(12'h5A4, 0, 0, 0, 0);
    chk(r_st == 2'b00, "R8", "status hit", 32'(r_st), 0);
    chk(r_ra == 32'h0012_35A4, "R3", "real address", r_ra, 32'h0012_35A4);
    chk(r_rd && r_wr, "R5", "code 2 rights", {30'd0, r_rd, r_wr}, 32'h3);
    chk(d_rd == 5, "R2", "reads for idx 3", 32'(d_rd), 5);
    chk(busy_ready == 0, "R1", "ready low while busy", 32'(busy_ready), 0);
    chk(d_wr == 1 && wlog[(n_wr - 1) & 3] == 4'b0100, "R6", "referenced byte write",
        32'(d_wr), 1);
    chk(mem[(PB + 28) >> 2] == 32'h0012_3102, "R6", "mapping word", mem[(PB + 28) >> 2],
        32'h0012_3102);
    chk(mem[(PB + 44) >> 2] == 32'h00AB_C002, "R2", "later entry untouched",
        mem[(PB + 44) >> 2], 32'h00AB_C002);
  endtask

  // S2: store, referenced already set, changed clear
  task automatic t_changed_only();
    clear_groups();
    poke(PB, CP); poke(PB + 4, 32'h0000_7100);
    walk(12'h010, 0, 0, 0, 1);
    chk(r_st == 2'b00, "R8", "store hit", 32'(r_st), 0);
    chk(d_wr == 1 && wlog[(n_wr - 1) & 3] == 4'b1000, "R7", "changed byte write",
        32'(d_wr), 1);
    chk(mem[(PB + 4) >> 2] == 32'h0000_7180, "R7", "mapping word", mem[(PB + 4) >> 2],
        32'h0000_7180);
  endtask

  // S3: store at last entry, both flags clear; slow memory
  task automatic t_both_flags();
    clear_groups();
    lat = 3;
    poke(PB + 56, CP); poke(PB + 60, 32'h0004_5001);
    walk(12'hFFF, 0, 0, 0, 1);
    lat = 0;
    chk(d_rd == 9, "R2", "reads for idx 7", 32'(d_rd), 9);
    chk(d_wr == 2 && wlog[(n_wr - 2) & 3] == 4'b0100 && wlog[(n_wr - 1) & 3] == 4'b1000,
        "R7", "referenced then changed", 32'(d_wr), 2);
    chk(mem[(PB + 60) >> 2] == 32'h0004_5181, "R6", "both flags", mem[(PB + 60) >> 2],
        32'h0004_5181);
    chk(r_ra == 32'h0004_5FFF, "R3", "offset all ones", r_ra, 32'h0004_5FFF);
    chk(hold_err == 0, "R10", "request held under wait", 32'(hold_err), 0);
  endtask

  // S4: user key with code 0 -> code 4, no rights, no writes
  task automatic t_code4();
    clear_groups();
    poke(PB + 8, CP); poke(PB + 12, 32'h0000_3000);
    walk(12'h0, 1, 1, 0, 0);
    chk(r_st == 2'b01, "R8", "code 4 fault", 32'(r_st), 1);
    chk(!r_rd && !r_wr, "R4", "code 4 rights", {30'd0, r_rd, r_wr}, 0);
    chk(d_wr == 0 && mem[(PB + 12) >> 2] == 32'h0000_3000, "R5", "no flag on code 4",
        mem[(PB + 12) >> 2], 32'h0000_3000);
  endtask

  // S5: store to read-only code 3: referenced set, fault
  task automatic t_readonly_store();
    clear_groups();
    poke(PB + 16, CP); poke(PB + 20, 32'h0000_5003);
    walk(12'h0, 0, 0, 0, 1);
    chk(r_st == 2'b01, "R8", "read-only store fault", 32'(r_st), 1);
    chk(r_rd && !r_wr, "R5", "code 3 rights", {30'd0, r_rd, r_wr}, 32'h2);
    chk(d_wr == 1 && mem[(PB + 20) >> 2] == 32'h0000_5103, "R8", "referenced before fault",
        mem[(PB + 20) >> 2], 32'h0000_5103);
  endtask

  // S6: key mode selection
  task automatic t_keys();
    clear_groups();
    poke(PB, CP); poke(PB + 4, 32'h0000_6101);
    walk(12'h0, 1, 0, 1, 1);
    chk(r_st == 2'b00 && r_wr, "R4", "supervisor key ignored in user mode", 32'(r_st), 0);
    poke(PB + 4, 32'h0000_6182);
    walk(12'h0, 0, 1, 1, 1);
    chk(r_st == 2'b00 && r_rd && r_wr, "R5", "code 6 writable", {30'd0, r_rd, r_wr}, 3);
    poke(PB + 4, 32'h0000_6181);
    walk(12'h0, 0, 0, 1, 0);
    chk(r_st == 2'b00 && r_rd && !r_wr, "R5", "code 5 read only", {30'd0, r_rd, r_wr}, 2);
  endtask

  // S7: secondary hit; secondary tag planted in primary must not match there
  task automatic t_secondary();
    clear_groups();
    poke(PB, CS);
    poke(SB + 16, CS); poke(SB + 20, 32'h0009_9103);
    walk(12'h123, 0, 0, 0, 0);
    chk(r_st == 2'b00, "R9", "secondary hit", 32'(r_st), 0);
    chk(r_ra == 32'h0009_9123, "R9", "secondary address", r_ra, 32'h0009_9123);
    chk(d_rd == 12, "R9", "reads 8 + 4", 32'(d_rd), 12);
    chk(d_wr == 0, "R6", "referenced already set", 32'(d_wr), 0);
  endtask

  // S8: miss in both groups
  task automatic t_miss();
    clear_groups();
    walk(12'h0, 0, 0, 0, 1);
    chk(r_st == 2'b10, "R9", "not found", 32'(r_st), 2);
    chk(d_rd == 16 && d_wr == 0, "R9", "16 reads no writes", 32'(d_rd), 16);
    chk(!r_rd && !r_wr, "R9", "no rights on miss", {30'd0, r_rd, r_wr}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !mem_req, "R1", "reset state", {29'd0, req_ready, done, mem_req},
        32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mem_req, "R11", "idle after reset",
        {29'd0, req_ready, done, mem_req}, 32'h4);
    t_first_match();
    t_changed_only();
    t_both_flags();
    t_code4();
    t_readonly_store();
    t_keys();
    t_secondary();
    t_miss();
    if (wdog_hit) chk(1'b0, "R11", "watchdog expired", 32'(cycles), WDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule